// File: doc/BRIEF.md
# Multi-Mode LCD Sync Timing Generator

This block produces the raster timing for a 320x240 TFT panel: an active-low horizontal sync, an active-low vertical sync, a flag for the horizontal active window, and a strobe that marks every bus tick carrying pixel data on a visible line. It also outputs the current tick-within-line and line-within-frame counters, so a downstream pixel formatter or fetch engine can follow the raster.

The pixel bus runs in one of three modes. In the first, a full 16-bit 5-6-5 pixel moves every clock. In the other two, each pixel is split into 2 or 3 byte beats on an 8-bit bus. Every horizontal count is given in bus ticks and multiplied by the clocks-per-pixel factor of the mode. The start of the active window is pushed later by a small per-mode correction, which absorbs the delay of the byte-packing stage that follows the generator. The mode is captured only while the block is disabled. Raising `enable` starts a frame from line 0, tick 0.

Top module: `lcdt_sync_gen`

## Requirements
- R1: The `mode` code sets the clocks-per-pixel factor `cpp` and the correction `cor`: code 0 gives cpp=1, cor=0; code 1 gives cpp=2, cor=3; code 2 gives cpp=3, cor=5. Code 3 is rejected: the block stays idle (syncs high, strobes low, counters zero) even with `enable` high.
- R2: While running, `x_pos` counts bus ticks from 0 to 336*cpp-1 and then returns to 0, so a line lasts 336*cpp ticks.
- R3: `hsync_n` is low during ticks 0 to 2*cpp-1 of every line and high for the rest of the line.
- R4: `line_active` is high for ticks 7*cpp+cor up to, but not including, 7*cpp+cor+320*cpp of every line. That is 320*cpp ticks.
- R5: `y_pos` advances by one in the tick after `x_pos` wraps. It returns to 0 after the last line, which is 243 with default parameters: 240 visible lines plus 4 blanking lines.
- R6: `vsync_n` is low only during ticks 0 to 2*cpp-1 of line 0, and high at all other times.
- R7: `pix_beat` equals `line_active` on visible lines (`y_pos` below 240 by default) and is low on the blanking lines.
- R8: One clock edge after `enable` is sampled low, all outputs are idle (`hsync_n`=`vsync_n`=1, `line_active`=`pix_beat`=0, `x_pos`=`y_pos`=0). In the first cycle after `enable` is sampled high, the raster restarts at `x_pos`=0, `y_pos`=0.
- R9: `mode` is sampled only on edges where `enable` is low. A change of `mode` while enabled leaves the timing unchanged.
- R10: After reset, the outputs are idle and remain idle until `enable` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all counts are in its ticks |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the raster when high; idle and clear when low |
| mode | input | 2 | Bus mode code (0, 1, 2 valid; 3 rejected) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| line_active | output | 1 | Tick lies in the horizontal active window |
| pix_beat | output | 1 | Pixel data beat on a visible line |
| x_pos | output | HCW | Tick index within the current line |
| y_pos | output | VCW | Line index within the current frame |

## Verification
Line wrap and frame wrap fall on the same tick at the end of the last blanking line. The vertical sync and the horizontal sync then start together in the next tick. The bench runs every valid mode through a full frame and into the next frame, so that tick is exercised in each mode. A scoreboard model of the timing predicts `x_pos`, `y_pos`, both syncs and both strobes for every tick. A mode change while enabled is applied in the middle of a frame, and its stream of expected values is left unchanged. A disable is issued in the middle of a line.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  localparam int unsigned LCDT_MODES   = 3;
  localparam int unsigned LCDT_CPP_MAX = 3;

  typedef enum logic [1:0] {
    LCDT_WIDE565 = 2'd0,
    LCDT_BYTE565 = 2'd1,
    LCDT_BYTE888 = 2'd2,
    LCDT_REJECT  = 2'd3
  } lcdt_mode_e;

  // bus ticks spent on one pixel
  function automatic int unsigned lcdt_cpp(int unsigned m);
    return m + 1;
  endfunction

  // extra lead ticks covering the downstream byte packer
  function automatic int unsigned lcdt_cor(int unsigned m);
    case (m)
      0:       return 0;
      1:       return 3;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/lcdt_mode_cfg.sv
module lcdt_mode_cfg
  import lcdt_pkg::*;
#(
  parameter int unsigned H_ACTIVE = 320,
  parameter int unsigned H_TOTAL  = 336,
  parameter int unsigned H_SYNC   = 2,
  parameter int unsigned H_LEAD   = 7,
  parameter int unsigned V_SYNC   = 2,
  parameter int unsigned HCW      = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [1:0]     mode,
  output logic           cfg_ok,
  output logic [HCW-1:0] hs_end,
  output logic [HCW-1:0] vs_end,
  output logic [HCW-1:0] act_start,
  output logic [HCW-1:0] act_end,
  output logic [HCW-1:0] line_last
);

  logic [HCW-1:0] tbl_hs   [LCDT_MODES];
  logic [HCW-1:0] tbl_vs   [LCDT_MODES];
  logic [HCW-1:0] tbl_as   [LCDT_MODES];
  logic [HCW-1:0] tbl_ae   [LCDT_MODES];
  logic [HCW-1:0] tbl_last [LCDT_MODES];

  for (genvar m = 0; m < LCDT_MODES; m++) begin : g_mode
    localparam int unsigned CPP = lcdt_cpp(m);
    localparam int unsigned AS  = H_LEAD * CPP + lcdt_cor(m);
    assign tbl_hs[m]   = HCW'(H_SYNC * CPP);
    assign tbl_vs[m]   = HCW'(V_SYNC * CPP);
    assign tbl_as[m]   = HCW'(AS);
    assign tbl_ae[m]   = HCW'(AS + H_ACTIVE * CPP);
    assign tbl_last[m] = HCW'(H_TOTAL * CPP - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_ok    <= 1'b0;
      hs_end    <= '0;
      vs_end    <= '0;
      act_start <= '0;
      act_end   <= '0;
      line_last <= '0;
    end else if (!enable) begin
      if (mode != LCDT_REJECT) begin
        cfg_ok    <= 1'b1;
        hs_end    <= tbl_hs[mode];
        vs_end    <= tbl_vs[mode];
        act_start <= tbl_as[mode];
        act_end   <= tbl_ae[mode];
        line_last <= tbl_last[mode];
      end else begin
        cfg_ok <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lcdt_hcount.sv
module lcdt_hcount #(
  parameter int unsigned HCW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_d,
  input  logic           run_q,
  input  logic [HCW-1:0] line_last,
  output logic [HCW-1:0] x_cnt,
  output logic           line_wrap
);

  assign line_wrap = run_q && (x_cnt == line_last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_d || !run_q) x_cnt <= '0;
    else if (line_wrap)             x_cnt <= '0;
    else                            x_cnt <= x_cnt + 1'b1;
  end

endmodule

// File: rtl/lcdt_vcount.sv
module lcdt_vcount #(
  parameter int unsigned V_TOTAL = 244,
  parameter int unsigned VCW     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_d,
  input  logic           run_q,
  input  logic           line_wrap,
  output logic [VCW-1:0] y_cnt
);

  localparam logic [VCW-1:0] Y_LAST = VCW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_d || !run_q) y_cnt <= '0;
    else if (line_wrap) y_cnt <= (y_cnt == Y_LAST) ? '0 : y_cnt + 1'b1;
  end

endmodule

// File: rtl/lcdt_sync_gen.sv
module lcdt_sync_gen
  import lcdt_pkg::*;
#(
  parameter int unsigned H_ACTIVE = 320,
  parameter int unsigned H_TOTAL  = 336,
  parameter int unsigned H_SYNC   = 2,
  parameter int unsigned H_LEAD   = 7,
  parameter int unsigned V_ACTIVE = 240,
  parameter int unsigned V_BLANK  = 4,
  parameter int unsigned V_SYNC   = 2,
  localparam int unsigned V_TOTAL = V_ACTIVE + V_BLANK,
  localparam int unsigned HCW     = $clog2(H_TOTAL * LCDT_CPP_MAX),
  localparam int unsigned VCW     = $clog2(V_TOTAL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [1:0]     mode,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic           line_active,
  output logic           pix_beat,
  output logic [HCW-1:0] x_pos,
  output logic [VCW-1:0] y_pos
);

  localparam logic [VCW-1:0] Y_VIS = VCW'(V_ACTIVE);

  logic           cfg_ok;
  logic [HCW-1:0] hs_end, vs_end, act_start, act_end, line_last;
  logic           run_d, run_q, line_wrap;
  logic [HCW-1:0] x_cnt;
  logic [VCW-1:0] y_cnt;

  lcdt_mode_cfg #(
    .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC),
    .H_LEAD(H_LEAD), .V_SYNC(V_SYNC), .HCW(HCW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .cfg_ok(cfg_ok), .hs_end(hs_end), .vs_end(vs_end),
    .act_start(act_start), .act_end(act_end), .line_last(line_last)
  );

  assign run_d = enable && cfg_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  lcdt_hcount #(.HCW(HCW)) u_h (
    .clk(clk), .rst_n(rst_n), .run_d(run_d), .run_q(run_q),
    .line_last(line_last), .x_cnt(x_cnt), .line_wrap(line_wrap)
  );

  lcdt_vcount #(.V_TOTAL(V_TOTAL), .VCW(VCW)) u_v (
    .clk(clk), .rst_n(rst_n), .run_d(run_d), .run_q(run_q),
    .line_wrap(line_wrap), .y_cnt(y_cnt)
  );

  logic in_win;
  assign in_win      = run_q && (x_cnt >= act_start) && (x_cnt < act_end);
  assign hsync_n     = !(run_q && (x_cnt < hs_end));
  assign vsync_n     = !(run_q && (y_cnt == '0) && (x_cnt < vs_end));
  assign line_active = in_win;
  assign pix_beat    = in_win && (y_cnt < Y_VIS);
  assign x_pos       = x_cnt;
  assign y_pos       = y_cnt;

endmodule

// File: rtl/lcdt_sync_chk.sv
module lcdt_sync_chk #(
  parameter int unsigned HCW      = 10,
  parameter int unsigned VCW      = 8,
  parameter int unsigned V_ACTIVE = 240
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           hsync_n,
  input logic           vsync_n,
  input logic           line_active,
  input logic           pix_beat,
  input logic [HCW-1:0] x_pos,
  input logic [VCW-1:0] y_pos
);

  p_idle_after_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (hsync_n && vsync_n && !line_active && !pix_beat &&
                 x_pos == '0 && y_pos == '0));

  p_x_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (x_pos != '0) |-> (x_pos == HCW'($past(x_pos) + 1'b1)));

  p_y_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_pos) |-> (x_pos == '0));

  p_vs_inside_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> (!hsync_n && y_pos == '0));

  p_window_clear_of_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_active |-> hsync_n);

  p_beat_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_beat |-> (line_active && y_pos < VCW'(V_ACTIVE)));

endmodule

bind lcdt_sync_gen lcdt_sync_chk #(
  .HCW(HCW), .VCW(VCW), .V_ACTIVE(V_ACTIVE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .hsync_n(hsync_n),
  .vsync_n(vsync_n), .line_active(line_active), .pix_beat(pix_beat),
  .x_pos(x_pos), .y_pos(y_pos)
);

// File: tb/tb_lcdt_sync_gen.sv
module tb_lcdt_sync_gen;

  // short frame keeps full-frame runs of every mode within budget
  localparam int VA  = 6;
  localparam int VB  = 4;
  localparam int VT  = VA + VB;
  localparam int HCW = $clog2(336 * 3);
  localparam int VCW = $clog2(VT);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           enable = 1'b0;
  logic [1:0]     mode = 2'd0;
  logic           hsync_n, vsync_n, line_active, pix_beat;
  logic [HCW-1:0] x_pos;
  logic [VCW-1:0] y_pos;

  always #5 clk = ~clk;

  lcdt_sync_gen #(.V_ACTIVE(VA), .V_BLANK(VB)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .line_active(line_active),
    .pix_beat(pix_beat), .x_pos(x_pos), .y_pos(y_pos)
  );

  typedef struct {
    int    hs, vs, la, pb, x, y;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic exp_t model(int cpp, int cor, int t);
    exp_t e;
    int ht, st;
    ht  = 336 * cpp;
    st  = 7 * cpp + cor;
    e.x = t % ht;
    e.y = (t / ht) % VT;
    e.hs = (e.x < 2 * cpp) ? 0 : 1;
    e.vs = (e.y == 0 && e.x < 2 * cpp) ? 0 : 1;
    e.la = (e.x >= st && e.x < st + 320 * cpp) ? 1 : 0;
    e.pb = (e.la == 1 && e.y < VA) ? 1 : 0;
    e.tag = "";
    return e;
  endfunction

  function automatic exp_t idle_exp(string tag);
    exp_t e;
    e.hs = 1; e.vs = 1; e.la = 0; e.pb = 0; e.x = 0; e.y = 0;
    e.tag = tag;
    return e;
  endfunction

  // monitor: samples 3 ns after each rising edge
  initial forever begin
    @(posedge clk);
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag != "" ? e.tag : "R3", int'(hsync_n),     e.hs);
      chk(e.tag != "" ? e.tag : "R6", int'(vsync_n),     e.vs);
      chk(e.tag != "" ? e.tag : "R4", int'(line_active), e.la);
      chk(e.tag != "" ? e.tag : "R7", int'(pix_beat),    e.pb);
      chk(e.tag != "" ? e.tag : "R2", int'(x_pos),       e.x);
      chk(e.tag != "" ? e.tag : "R5", int'(y_pos),       e.y);
    end
  end

  task automatic hold_idle(int n, bit en, string tag);
    enable = en;
    for (int i = 0; i < n; i++) begin
      q.push_back(idle_exp(tag));
      @(negedge clk);
    end
  endtask

  // R1: each valid code gives its cpp/cor; optional R9 mode flip mid-run
  task automatic run_mode(int m, int cpp, int cor, int n, int flip_at);
    mode = 2'(m);
    hold_idle(1, 1'b0, "R8");
    enable = 1'b1;
    for (int t = 0; t < n; t++) begin
      if (t == flip_at) mode = 2'd3;   // R9: ignored while enabled
      q.push_back(model(cpp, cor, t));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold_idle(4, 1'b0, "R10");
    run_mode(0, 1, 0, 336 * VT + 400, -1);          // R1 R2 R5 frame wrap
    hold_idle(3, 1'b0, "R8");
    run_mode(1, 2, 3, 672 * VT + 50, 1000);         // R9 flip mid-frame
    hold_idle(3, 1'b0, "R8");
    run_mode(2, 3, 5, 2000, -1);                    // disable mid-line
    hold_idle(3, 1'b0, "R8");
    run_mode(2, 3, 5, 1008 * VT + 40, -1);          // R8 clean restart
    hold_idle(2, 1'b0, "R8");
    mode = 2'd3;
    hold_idle(2, 1'b0, "R1");
    hold_idle(40, 1'b1, "R1");                      // R1 rejected code idles
    enable = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
    chk("R1", q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule